// File: doc/BRIEF.md
# Two-Port Bridge Cycle Claim Controller

This block decides how a two-port bus bridge answers a bus cycle that starts on either of its ports. Each cycle arrives as a one-cycle start strobe. With the strobe come the originating port, the address, the command, the direction, and two window-decode hits that say whether the address lies on the primary side or on the secondary side. The block stays silent when the target is on the originating side. It also stays silent when no window claims the address, so the initiator ends in master abort. On the primary port it stays silent as well when another device has already claimed the cycle with its own device-select.

When the target lies across the bridge, the block asserts device-select on the originating port and picks a termination. Memory writes are completed at once if the posting buffer has room, and are forwarded to the other port. Every other claimed cycle is retried. A non-postable cycle is stored as the single outstanding delayed transaction and forwarded. When the initiator repeats that exact cycle after the forwarded transfer has finished, the block completes it normally and frees the entry.

All results are registered and appear one clock after the start strobe, as one-cycle pulses. The data path, the FIFOs, arbitration and configuration are outside this block.

Top module: `bridge_claim_ctrl`

## Requirements
- R1: After reset, `term` is 00 and `devsel_pri`, `devsel_sec` and `fwd_req` are 0. No delayed transaction is pending, so the first non-postable claimed cycle is stored.
- R2: A cycle whose address hits the originating side's window is not answered: `term`=00, no device-select and no forward request. This holds whether or not the other window also hits. Primary is port 0 and secondary is port 1.
- R3: A cycle that hits neither window is not answered (`term`=00, no device-select, no forward), so the initiator sees master abort.
- R4: A cycle from port 0 with `early_claim` high is not answered even if it targets the far side. `early_claim` has no effect on cycles from port 1.
- R5: A claimed cycle (far window hit, near window miss, not pre-empted) raises exactly the originating port's device-select, and `term` is 01 (normal) or 10 (retry). Both appear one clock after `cyc_start`.
- R6: A postable cycle is a write (`cyc_write`=1) with command 0111 or 1111. If it is claimed while `post_avail`=1, it ends with `term`=01. In the same cycle it raises `fwd_req`, with `fwd_port` set to the opposite port and the cycle's address, command and direction.
- R7: A claimed postable cycle with `post_avail`=0 ends with `term`=10 and is not forwarded.
- R8: A claimed non-postable cycle with no entry pending ends with `term`=10. It raises `fwd_req` with the cycle's fields and becomes the pending entry.
- R9: A claimed cycle that matches the pending entry before `fwd_done` has been seen ends with `term`=10 and is not forwarded again. A `fwd_done` pulse in the same cycle as the repeat takes effect only for later repeats.
- R10: A matching repeat claimed after `fwd_done` ends with `term`=01 without a forward request and frees the entry. The next non-postable claimed cycle is then stored and forwarded.
- R11: While an entry is pending, a claimed non-postable cycle that does not match ends with `term`=10. It is not forwarded and leaves the pending entry unchanged.
- R12: A match requires the origin port, address, command and direction all to equal the stored ones. A difference in any one of them counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-cycle strobe: a bus cycle starts |
| cyc_port | input | 1 | Originating port: 0 primary, 1 secondary |
| cyc_addr | input | AW | Cycle address |
| cyc_cmd | input | CW | Bus command |
| cyc_write | input | 1 | 1 for a write, 0 for a read |
| hit_pri | input | 1 | Address falls in the primary-side window |
| hit_sec | input | 1 | Address falls in the secondary-side window |
| post_avail | input | 1 | Posting buffer can accept a write |
| early_claim | input | 1 | Another primary-side device already asserted device-select |
| fwd_done | input | 1 | Forwarded delayed transfer has completed on the far port |
| devsel_pri | output | 1 | Device-select toward the primary port |
| devsel_sec | output | 1 | Device-select toward the secondary port |
| term | output | 2 | 00 no response, 01 normal, 10 retry |
| fwd_req | output | 1 | Request to run the cycle on the opposite port |
| fwd_port | output | 1 | Destination port of the forward request |
| fwd_addr | output | AW | Forwarded address |
| fwd_cmd | output | CW | Forwarded command |
| fwd_write | output | 1 | Forwarded direction |

## Verification
Every result of this block is due exactly one clock after the `cyc_start` it answers: device-select, termination code and forward request. The pending entry changes on that same edge, and a `fwd_done` pulse only affects repeats that begin at least one clock later. The bench drives each stimulus on a falling edge and compares all outputs on the next falling edge, which falls between the one register stage and the following edge. It updates its own model of the pending entry only after that comparison, so a repeat arriving in the same cycle as `fwd_done` is expected to see the old state.

// File: rtl/bridge_claim_ctrl.sv
module bridge_claim_ctrl #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter logic [CW-1:0] POST_CMD_A = 4'h7,
  parameter logic [CW-1:0] POST_CMD_B = 4'hF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_start,
  input  logic          cyc_port,
  input  logic [AW-1:0] cyc_addr,
  input  logic [CW-1:0] cyc_cmd,
  input  logic          cyc_write,
  input  logic          hit_pri,
  input  logic          hit_sec,
  input  logic          post_avail,
  input  logic          early_claim,
  input  logic          fwd_done,
  output logic          devsel_pri,
  output logic          devsel_sec,
  output logic [1:0]    term,
  output logic          fwd_req,
  output logic          fwd_port,
  output logic [AW-1:0] fwd_addr,
  output logic [CW-1:0] fwd_cmd,
  output logic          fwd_write
);
  localparam logic [1:0] T_NONE   = 2'b00;
  localparam logic [1:0] T_NORMAL = 2'b01;
  localparam logic [1:0] T_RETRY  = 2'b10;

  logic          pend_valid, pend_done, pend_port, pend_write;
  logic [AW-1:0] pend_addr;
  logic [CW-1:0] pend_cmd;

  wire near_hit  = cyc_port ? hit_sec : hit_pri;
  wire far_hit   = cyc_port ? hit_pri : hit_sec;
  wire preempted = !cyc_port && early_claim;
  wire claim     = cyc_start && far_hit && !near_hit && !preempted;
  wire postable  = cyc_write && (cyc_cmd == POST_CMD_A || cyc_cmd == POST_CMD_B);
  wire match     = pend_valid && pend_port == cyc_port && pend_addr == cyc_addr &&
                   pend_cmd == cyc_cmd && pend_write == cyc_write;

  logic [1:0] nxt_term;
  logic       nxt_fwd, do_latch, do_release;

  always_comb begin
    nxt_term   = T_NONE;
    nxt_fwd    = 1'b0;
    do_latch   = 1'b0;
    do_release = 1'b0;
    if (claim) begin
      if (postable) begin
        nxt_term = post_avail ? T_NORMAL : T_RETRY;
        nxt_fwd  = post_avail;
      end else if (!pend_valid) begin
        nxt_term = T_RETRY;
        nxt_fwd  = 1'b1;
        do_latch = 1'b1;
      end else if (match && pend_done) begin
        nxt_term   = T_NORMAL;
        do_release = 1'b1;
      end else begin
        nxt_term = T_RETRY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      devsel_pri <= 1'b0;
      devsel_sec <= 1'b0;
      term       <= T_NONE;
      fwd_req    <= 1'b0;
      fwd_port   <= 1'b0;
      fwd_addr   <= '0;
      fwd_cmd    <= '0;
      fwd_write  <= 1'b0;
    end else begin
      devsel_pri <= claim && !cyc_port;
      devsel_sec <= claim && cyc_port;
      term       <= nxt_term;
      fwd_req    <= nxt_fwd;
      if (nxt_fwd) begin
        fwd_port  <= !cyc_port;
        fwd_addr  <= cyc_addr;
        fwd_cmd   <= cyc_cmd;
        fwd_write <= cyc_write;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_done  <= 1'b0;
      pend_port  <= 1'b0;
      pend_addr  <= '0;
      pend_cmd   <= '0;
      pend_write <= 1'b0;
    end else if (do_latch) begin
      pend_valid <= 1'b1;
      pend_done  <= 1'b0;
      pend_port  <= cyc_port;
      pend_addr  <= cyc_addr;
      pend_cmd   <= cyc_cmd;
      pend_write <= cyc_write;
    end else if (do_release) begin
      pend_valid <= 1'b0;
      pend_done  <= 1'b0;
    end else if (pend_valid && fwd_done) begin
      pend_done <= 1'b1;
    end
  end

  assert_devsel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({devsel_pri, devsel_sec}));

  assert_silent_near_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && near_hit) |=> (term == T_NONE && !devsel_pri && !devsel_sec && !fwd_req));

  assert_silent_nohit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !hit_pri && !hit_sec) |=> (term == T_NONE && !fwd_req));

  assert_preempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !cyc_port && early_claim) |=> (!devsel_pri && term == T_NONE));

  assert_fwd_claimed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_req |-> ((devsel_pri && fwd_port) || (devsel_sec && !fwd_port)));

  assert_early_repeat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !postable && match && !pend_done) |=> (term == T_RETRY && !fwd_req));

  assert_keep_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !postable && pend_valid && !match) |=> (pend_valid && $stable(pend_addr) && !fwd_req));
endmodule

// File: tb/tb_bridge_claim_ctrl.sv
module tb_bridge_claim_ctrl;
  localparam int AW = 32;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 0, cyc_port = 0, cyc_write = 0;
  logic [AW-1:0] cyc_addr = '0;
  logic [CW-1:0] cyc_cmd = '0;
  logic hit_pri = 0, hit_sec = 0, post_avail = 0, early_claim = 0, fwd_done = 0;
  logic devsel_pri, devsel_sec, fwd_req, fwd_port, fwd_write;
  logic [1:0] term;
  logic [AW-1:0] fwd_addr;
  logic [CW-1:0] fwd_cmd;

  always #5 clk = ~clk;

  bridge_claim_ctrl #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_port(cyc_port),
    .cyc_addr(cyc_addr), .cyc_cmd(cyc_cmd), .cyc_write(cyc_write),
    .hit_pri(hit_pri), .hit_sec(hit_sec), .post_avail(post_avail),
    .early_claim(early_claim), .fwd_done(fwd_done),
    .devsel_pri(devsel_pri), .devsel_sec(devsel_sec), .term(term),
    .fwd_req(fwd_req), .fwd_port(fwd_port), .fwd_addr(fwd_addr),
    .fwd_cmd(fwd_cmd), .fwd_write(fwd_write));

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // model of the pending delayed transaction
  bit m_valid = 0, m_done = 0, m_port = 0, m_write = 0;
  logic [AW-1:0] m_addr = '0;
  logic [CW-1:0] m_cmd = '0;

  function automatic bit is_postable(logic wr, logic [CW-1:0] c);
    return wr && (c == 4'h7 || c == 4'hF);
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit st, bit pt, logic [AW-1:0] a, logic [CW-1:0] c, bit wr,
                      bit hp, bit hs, bit pa, bit ec, bit dn);
    bit near, far, claim, post, match;
    bit [1:0] e_term;
    bit e_fwd, latch, rel;
    string req;
    @(negedge clk);
    cyc_start = st; cyc_port = pt; cyc_addr = a; cyc_cmd = c; cyc_write = wr;
    hit_pri = hp; hit_sec = hs; post_avail = pa; early_claim = ec; fwd_done = dn;
    near  = pt ? hs : hp;
    far   = pt ? hp : hs;
    claim = st && far && !near && !(!pt && ec);
    post  = is_postable(wr, c);
    match = m_valid && m_port == pt && m_addr == a && m_cmd == c && m_write == wr;
    e_term = 2'b00; e_fwd = 0; latch = 0; rel = 0;
    if (!st) req = "R1";
    else if (near) req = "R2";
    else if (!far) req = "R3";
    else if (!pt && ec) req = "R4";
    else req = "R5";
    if (claim) begin
      if (post) begin
        e_term = pa ? 2'b01 : 2'b10; e_fwd = pa; req = pa ? "R6" : "R7";
      end else if (!m_valid) begin
        e_term = 2'b10; e_fwd = 1; latch = 1; req = "R8";
      end else if (match && m_done) begin
        e_term = 2'b01; rel = 1; req = "R10";
      end else if (match) begin
        e_term = 2'b10; req = "R9";
      end else begin
        e_term = 2'b10; req = "R11";
      end
    end
    @(negedge clk);
    cyc_start = 0; fwd_done = 0;
    check(req, "term", term, e_term);
    check(req, "devsel_pri", devsel_pri, claim && !pt);
    check(req, "devsel_sec", devsel_sec, claim && pt);
    check(req, "fwd_req", fwd_req, e_fwd);
    if (e_fwd) begin
      check(req, "fwd_port", fwd_port, !pt);
      check(req, "fwd_addr", fwd_addr, a);
      check(req, "fwd_cmd", fwd_cmd, c);
      check(req, "fwd_write", fwd_write, wr);
    end
    if (latch) begin
      m_valid = 1; m_done = 0; m_port = pt; m_addr = a; m_cmd = c; m_write = wr;
    end else if (rel) begin
      m_valid = 0; m_done = 0;
    end else if (m_valid && dn) m_done = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] addrs [4];
    logic [CW-1:0] cmds [5];
    void'($urandom(32'h5eed_1234));
    addrs[0] = 32'h1000_0000; addrs[1] = 32'h1000_0040;
    addrs[2] = 32'h8000_0004; addrs[3] = 32'hFFFF_FFFC;
    cmds[0] = 4'h6; cmds[1] = 4'h7; cmds[2] = 4'h2; cmds[3] = 4'h3; cmds[4] = 4'hF;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "term", term, 0);
    check("R1", "devsel", {devsel_pri, devsel_sec}, 0);
    check("R1", "fwd_req", fwd_req, 0);
    rst_n = 1;
    // R2 same side, including both windows hit
    step(1, 0, addrs[0], 4'h6, 0, 1, 0, 1, 0, 0);
    step(1, 1, addrs[0], 4'h6, 0, 0, 1, 1, 0, 0);
    step(1, 0, addrs[0], 4'h7, 1, 1, 1, 1, 0, 0);
    // R3 no window
    step(1, 1, addrs[1], 4'h6, 0, 0, 0, 1, 0, 0);
    // R4 pre-empted on primary; ignored on secondary
    step(1, 0, addrs[1], 4'h7, 1, 0, 1, 1, 1, 0);
    step(1, 1, addrs[1], 4'h7, 1, 1, 0, 1, 1, 0);
    // R6 / R7 posted writes
    step(1, 0, addrs[2], 4'hF, 1, 0, 1, 1, 0, 0);
    step(1, 0, addrs[2], 4'h7, 1, 0, 1, 0, 0, 0);
    // R8 latch read, R9 early repeat, R11/R12 mismatches, R10 completion
    step(1, 0, addrs[0], 4'h6, 0, 0, 1, 1, 0, 0);
    step(1, 0, addrs[0], 4'h6, 0, 0, 1, 1, 0, 1);   // R9: done arrives same cycle
    step(1, 1, addrs[0], 4'h6, 0, 1, 0, 1, 0, 0);   // R12 other port
    step(1, 0, addrs[1], 4'h6, 0, 0, 1, 1, 0, 0);   // R12 other address
    step(1, 0, addrs[0], 4'h2, 0, 0, 1, 1, 0, 0);   // R12 other command
    step(1, 0, addrs[0], 4'h6, 1, 0, 1, 1, 0, 0);   // R12 other direction
    step(1, 0, addrs[0], 4'h6, 0, 0, 1, 1, 0, 0);   // R10 completes
    step(1, 1, addrs[3], 4'h3, 1, 1, 0, 1, 0, 0);   // R10 new entry latched
    step(0, 0, '0, 4'h0, 0, 0, 0, 0, 0, 1);
    step(1, 1, addrs[3], 4'h3, 1, 1, 0, 0, 0, 0);   // R10 completes with no posting room
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 9) < 7, $urandom_range(0, 1),
           addrs[$urandom_range(0, 3)], cmds[$urandom_range(0, 4)], $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3) != 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 6) == 0);
    end
    finish_run();
  end
endmodule